// File: doc/BRIEF.md
# Toggle-Bit Flash Completion Poller

Once a host has launched a program or erase inside a parallel NOR flash, this block finds out when the embedded operation has ended. The host gives it one status address and a budget in clock cycles, then pulses a start request. The poller reads that address twice in a row over a simple request/acknowledge read port. A bit that stops toggling between the two reads means the operation is over. A separate fault bit starts one confirming pair of reads before the poller reports a failure.

The outcome is a 2-bit code that is valid in the single cycle in which `done_o` pulses. A budget of zero gives a timeout at once, without any bus read. A budget of all ones turns the time limit off. Any other value stops polling once the elapsed cycle count exceeds it. The block needs no software interface: the start pulse and the done pulse are the whole protocol. The positions of the toggle and fault bits are parameters, with defaults of 6 and 5.

Top module: `flash_toggle_poller`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `rd_req_o` are all low.
- R2: Every poll step issues exactly two reads, one after the other. Each read is a one-cycle `rd_req_o` pulse, and each one targets the address captured at start.
- R3: If bit TOG_BIT (default 6) has the same value in both words of a pair, the poll ends with result 2'b00 (success).
- R4: If bit TOG_BIT differs and bit FLT_BIT (default 5) of the first word is clear, another pair is read.
- R5: If bit TOG_BIT differs and bit FLT_BIT of the first word is set, a confirming pair is read. If bit TOG_BIT is equal in that pair, the result is 2'b00.
- R6: If a confirming pair still differs in bit TOG_BIT and its first word has bit FLT_BIT set, the result is 2'b01 (error).
- R7: If a confirming pair differs in bit TOG_BIT but its first word has bit FLT_BIT clear, normal polling resumes.
- R8: A budget of zero ends the poll with result 2'b10 (timeout) in the cycle after start is accepted, and with no reads.
- R9: With a budget T that is neither zero nor all ones, the elapsed cycle count since start is compared with T before each pair. Once the count exceeds T, the poll ends with 2'b10, no later than one pair time after that point.
- R10: An all-ones budget never produces a timeout, however long the toggling lasts.
- R11: `done_o` is high for exactly one cycle per accepted start, and `result_o` is valid in that cycle. `busy_o` is high from the cycle after acceptance through the done cycle.
- R12: A start pulse while busy is ignored. The read address and the outcome of the running poll are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, accepted when idle |
| addr_i | input | AW | Status address to poll |
| timeout_i | input | TW | Cycle budget; zero = immediate timeout, all ones = no limit |
| busy_o | output | 1 | Poll in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2 | 00 success, 01 error, 10 timeout; valid with done_o |
| rd_req_o | output | 1 | One-cycle read request |
| rd_addr_o | output | AW | Read address |
| rd_ack_i | input | 1 | Read data valid |
| rd_data_i | input | DW | Read data word |

## Verification
A wrong verdict state would show up at the ports as the wrong read count before `done_o`: for example two reads where four were due after a fault-bit word, or a result code that differs from the scripted status words. Such an error is visible in the same transaction. A stale or clobbered capture register would appear on `rd_addr_o` at the next read request. A timer fault shifts the done pulse by more than one pair time against the budget, or produces a timeout under an all-ones budget. The bench scripts each status word per read and predicts both the read count and the result code.

// File: rtl/tpoll_pkg.sv
package tpoll_pkg;

  // Result codes seen at result_o
  typedef enum logic [1:0] {
    RES_OK  = 2'b00,
    RES_ERR = 2'b01,
    RES_TMO = 2'b10
  } res_e;

  // Verdict on one captured pair
  typedef enum logic [1:0] {
    V_SETTLED = 2'b00,
    V_RETRY   = 2'b01,
    V_CONFIRM = 2'b10,
    V_FAULT   = 2'b11
  } verdict_e;

endpackage

// File: rtl/tpoll_timer.sv
module tpoll_timer #(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          run_i,
  input  logic [TW-1:0] limit_i,
  output logic          expired_o
);

  localparam logic [TW-1:0] NO_LIMIT = {TW{1'b1}};

  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (clr_i) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (run_i && (cnt_q != NO_LIMIT)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired_o = (limit_i != NO_LIMIT) && (cnt_q > limit_i);

  // R9: once expired, it stays expired until cleared
  a_r9_expiry_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (expired_o && !clr_i && $stable(limit_i)) |=> expired_o);

endmodule

// File: rtl/tpoll_pair_reader.sv
module tpoll_pair_reader #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_i,
  output logic          rd_req_o,
  input  logic          rd_ack_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          pair_done_o,
  output logic [DW-1:0] first_o,
  output logic [DW-1:0] second_o
);

  typedef enum logic [1:0] {P_IDLE, P_REQ, P_WAIT} pst_e;

  pst_e          st_q, st_d;
  logic          sel_q, sel_d;
  logic          done_q, done_d;
  logic [DW-1:0] w0_q, w1_q;
  logic          w0_en, w1_en;

  always_comb begin
    st_d   = st_q;
    sel_d  = sel_q;
    done_d = 1'b0;
    w0_en  = 1'b0;
    w1_en  = 1'b0;
    case (st_q)
      P_IDLE: begin
        if (go_i) begin
          sel_d = 1'b0;
          st_d  = P_REQ;
        end
      end
      P_REQ: st_d = P_WAIT;
      P_WAIT: begin
        if (rd_ack_i) begin
          if (!sel_q) begin
            w0_en = 1'b1;
            sel_d = 1'b1;
            st_d  = P_REQ;
          end else begin
            w1_en  = 1'b1;
            done_d = 1'b1;
            st_d   = P_IDLE;
          end
        end
      end
      default: st_d = P_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= P_IDLE;
      sel_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      sel_q  <= sel_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w0_q <= '0;
    end else if (w0_en) begin
      w0_q <= rd_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w1_q <= '0;
    end else if (w1_en) begin
      w1_q <= rd_data_i;
    end
  end

  assign rd_req_o    = (st_q == P_REQ);
  assign pair_done_o = done_q;
  assign first_o     = w0_q;
  assign second_o    = w1_q;

  // R2: each request is a single-cycle pulse
  a_r2_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |=> !rd_req_o);

  // R2: a pair completes only after a second acknowledge
  a_r2_pair_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    pair_done_o |-> $past(rd_ack_i));

endmodule

// File: rtl/tpoll_judge.sv
module tpoll_judge
  import tpoll_pkg::*;
#(
  parameter int DW      = 16,
  parameter int TOG_BIT = 6,
  parameter int FLT_BIT = 5
) (
  input  logic [DW-1:0] first_i,
  input  logic [DW-1:0] second_i,
  input  logic          confirm_i,
  output verdict_e      verdict_o
);

  logic toggled;
  logic fault;

  assign toggled = first_i[TOG_BIT] ^ second_i[TOG_BIT];
  assign fault   = first_i[FLT_BIT];

  always_comb begin
    if (!toggled) begin
      verdict_o = V_SETTLED;
    end else if (fault) begin
      verdict_o = confirm_i ? V_FAULT : V_CONFIRM;
    end else begin
      verdict_o = V_RETRY;
    end
  end

endmodule

// File: rtl/flash_toggle_poller.sv
module flash_toggle_poller
  import tpoll_pkg::*;
#(
  parameter int AW      = 24,
  parameter int DW      = 16,
  parameter int TW      = 32,
  parameter int TOG_BIT = 6,
  parameter int FLT_BIT = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  input  logic [TW-1:0] timeout_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [1:0]    result_o,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_ack_i,
  input  logic [DW-1:0] rd_data_i
);

  typedef enum logic [1:0] {S_IDLE, S_CHECK, S_PAIR, S_FIN} st_e;

  st_e           st_q, st_d;
  logic [AW-1:0] addr_q;
  logic [TW-1:0] limit_q;
  logic          cap_en;
  logic          confirm_q, confirm_d;
  res_e          res_q, res_d;
  logic          timer_clr;
  logic          expired;
  logic          pair_go;
  logic          pair_done;
  logic [DW-1:0] w_first, w_second;
  verdict_e      verdict;

  tpoll_timer #(.TW(TW)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (timer_clr),
    .run_i     (busy_o),
    .limit_i   (limit_q),
    .expired_o (expired)
  );

  tpoll_pair_reader #(.DW(DW)) u_reader (
    .clk         (clk),
    .rst_n       (rst_n),
    .go_i        (pair_go),
    .rd_req_o    (rd_req_o),
    .rd_ack_i    (rd_ack_i),
    .rd_data_i   (rd_data_i),
    .pair_done_o (pair_done),
    .first_o     (w_first),
    .second_o    (w_second)
  );

  tpoll_judge #(.DW(DW), .TOG_BIT(TOG_BIT), .FLT_BIT(FLT_BIT)) u_judge (
    .first_i   (w_first),
    .second_i  (w_second),
    .confirm_i (confirm_q),
    .verdict_o (verdict)
  );

  always_comb begin
    st_d      = st_q;
    res_d     = res_q;
    confirm_d = confirm_q;
    cap_en    = 1'b0;
    timer_clr = 1'b0;
    pair_go   = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (start_i) begin
          cap_en    = 1'b1;
          timer_clr = 1'b1;
          confirm_d = 1'b0;
          if (timeout_i == '0) begin
            res_d = RES_TMO;
            st_d  = S_FIN;
          end else begin
            st_d  = S_CHECK;
          end
        end
      end
      S_CHECK: begin
        if (expired) begin
          res_d = RES_TMO;
          st_d  = S_FIN;
        end else begin
          pair_go = 1'b1;
          st_d    = S_PAIR;
        end
      end
      S_PAIR: begin
        if (pair_done) begin
          case (verdict)
            V_SETTLED: begin
              res_d = RES_OK;
              st_d  = S_FIN;
            end
            V_FAULT: begin
              res_d = RES_ERR;
              st_d  = S_FIN;
            end
            V_CONFIRM: begin
              confirm_d = 1'b1;
              st_d      = S_CHECK;
            end
            default: begin
              confirm_d = 1'b0;
              st_d      = S_CHECK;
            end
          endcase
        end
      end
      S_FIN:   st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      res_q     <= RES_OK;
      confirm_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      res_q     <= res_d;
      confirm_q <= confirm_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      limit_q <= '0;
    end else if (cap_en) begin
      addr_q  <= addr_i;
      limit_q <= timeout_i;
    end
  end

  assign busy_o    = (st_q != S_IDLE);
  assign done_o    = (st_q == S_FIN);
  assign result_o  = res_q;
  assign rd_addr_o = addr_q;

  // R11: done is a single-cycle pulse
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8: zero budget finishes next cycle with timeout
  a_r8_zero_budget: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && (timeout_i == '0)) |=> (done_o && (result_o == RES_TMO)));

  // R6: an error is only reported from a confirming pair
  a_r6_error_confirmed: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && (result_o == RES_ERR)) |-> confirm_q);

  // R12: address held for the whole poll
  a_r12_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(rd_addr_o));

  // R8: no read is issued in the done cycle
  a_r8_no_read_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !rd_req_o);

endmodule

// File: tb/tb_flash_toggle_poller.sv
module tb_flash_toggle_poller;

  localparam int AW  = 16;
  localparam int DW  = 16;
  localparam int TW  = 8;
  localparam int LAT = 2;

  logic          clk;
  logic          rst_n;
  logic          start_i;
  logic [AW-1:0] addr_i;
  logic [TW-1:0] timeout_i;
  logic          busy_o, done_o, rd_req_o, rd_ack_i;
  logic [1:0]    result_o;
  logic [AW-1:0] rd_addr_o;
  logic [DW-1:0] rd_data_i;

  flash_toggle_poller #(.AW(AW), .DW(DW), .TW(TW)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
    .timeout_i(timeout_i), .busy_o(busy_o), .done_o(done_o),
    .result_o(result_o), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
    .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct { logic [1:0] res; int reads; string tag; } exp_t;
  exp_t exp_q[$];

  int nchk = 0;
  int nfail = 0;
  bit finished = 0;

  // flash status model
  logic [DW-1:0] script [16];
  int slen = 0;
  int tog_end = 0;
  int reads = 0;
  logic [AW-1:0] cur_addr = '0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] word_at(input int i);
    if (i < slen) return script[i];
    if (i < tog_end) return i[0] ? 16'h0040 : 16'h0000;
    return 16'h1234;
  endfunction

  // responder: fixed latency acknowledge
  initial begin
    int cnt;
    cnt = 0;
    rd_ack_i = 1'b0;
    rd_data_i = '0;
    forever begin
      @(negedge clk);
      rd_ack_i = 1'b0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          rd_ack_i = 1'b1;
          rd_data_i = word_at(reads - 1);
        end
      end
      if (rd_req_o) begin
        reads++;
        if (rd_addr_o != cur_addr)
          chk(1'b0, "R2/R12 read address", int'(rd_addr_o), int'(cur_addr));
        cnt = LAT;
      end
    end
  end

  // monitor: pops expected outcome at each done pulse
  initial begin
    bit prev_done;
    prev_done = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (prev_done && done_o) chk(1'b0, "R11 done longer than one cycle", 1, 0);
        if (done_o && !prev_done) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R11/R12 unexpected done", 1, 0);
          end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk(result_o == e.res, {e.tag, " result"}, int'(result_o), int'(e.res));
            chk(busy_o == 1'b1, "R11 busy at done", int'(busy_o), 1);
            if (e.reads >= 0)
              chk(reads == e.reads, {e.tag, " read count"}, reads, e.reads);
          end
        end
        prev_done = done_o;
      end
    end
  end

  task automatic run_case(input string tag, input logic [AW-1:0] a, input logic [TW-1:0] tmo,
                          input int tend, input logic [1:0] eres, input int ereads,
                          input bit poke, output int cyc);
    exp_t e;
    tog_end = tend;
    reads = 0;
    cur_addr = a;
    e.res = eres; e.reads = ereads; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    start_i = 1'b1; addr_i = a; timeout_i = tmo;
    @(negedge clk);
    start_i = 1'b0; addr_i = ~a; timeout_i = 8'd0;
    cyc = 1;
    if (poke) begin
      repeat (5) @(negedge clk);
      cyc += 5;
      start_i = 1'b1;
      @(negedge clk);
      cyc++;
      start_i = 1'b0;
    end
    while (!done_o) begin
      @(negedge clk);
      cyc++;
    end
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, {tag, " outcome consumed"}, exp_q.size(), 0);
    chk(busy_o == 1'b0, {tag, " idle after done"}, int'(busy_o), 0);
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int cyc;
    rst_n = 1'b0;
    start_i = 1'b0;
    addr_i = '0;
    timeout_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy_o == 0, "R1 busy after reset", int'(busy_o), 0);
    chk(done_o == 0, "R1 done after reset", int'(done_o), 0);
    chk(rd_req_o == 0, "R1 read after reset", int'(rd_req_o), 0);

    // R3 settled on first pair
    slen = 0;
    run_case("R3 immediate settle", 16'h0A55, 8'hFF, 0, 2'b00, 2, 0, cyc);

    // R4 three toggling pairs then settle
    run_case("R4 retry pairs", 16'h1357, 8'hFF, 6, 2'b00, 8, 0, cyc);

    // R5 fault bit then confirming pair settles
    script[0] = 16'h0060; script[1] = 16'h0020; slen = 2;
    run_case("R5 confirm settles", 16'h2222, 8'hFF, 2, 2'b00, 4, 0, cyc);

    // R6 confirming pair still toggles with fault bit
    script[2] = 16'h0060; script[3] = 16'h0000; slen = 4;
    run_case("R6 confirmed fault", 16'h3333, 8'hFF, 100000, 2'b01, 4, 0, cyc);

    // R7 confirming pair toggles without fault bit: resume
    script[2] = 16'h0040; script[3] = 16'h0000; slen = 4;
    run_case("R7 resume polling", 16'h4444, 8'hFF, 8, 2'b00, 10, 0, cyc);
    slen = 0;

    // R8 zero budget
    run_case("R8 zero budget", 16'h5555, 8'h00, 100000, 2'b10, 0, 0, cyc);
    chk(cyc <= 2, "R8 immediate timeout latency", cyc, 2);

    // R9 finite budget with endless toggling
    run_case("R9 finite budget", 16'h6666, 8'd20, 100000, 2'b10, -1, 0, cyc);
    chk(cyc > 20 && cyc <= 32, "R9 timeout window", cyc, 21);

    // R9 largest finite budget
    run_case("R9 max finite budget", 16'h6767, 8'hFE, 100000, 2'b10, -1, 0, cyc);
    chk(cyc > 254 && cyc <= 266, "R9 max timeout window", cyc, 255);

    // R10 all-ones budget, toggling far beyond 255 cycles
    run_case("R10 no limit", 16'h7777, 8'hFF, 200, 2'b00, 202, 0, cyc);
    chk(cyc > 255, "R10 ran past counter range", cyc, 256);

    // R12 start pulse while busy with a different address
    run_case("R12 start while busy", 16'h8888, 8'hFF, 6, 2'b00, 8, 1, cyc);

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0 && !busy_o, "R11 no stray done", int'(busy_o), 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule